// File: doc/BRIEF.md
# Configurable GPIO Port with Address-Output Mode

This block is an 8-bit general-purpose I/O port that a microcontroller sets up through a small bank of memory-mapped configuration registers. Each pin has its own data-out bit, direction bit and mode bit. In I/O mode the pin drives the software data bit. In address-output mode the pin drives one bit of a locally latched low address byte. This lets an external memory or peripheral see a demultiplexed low address without extra glue logic.

Pin direction has two sources: a software direction bit, and a per-pin output-enable term that comes from neighbouring programmable logic. The pin's tri-state enable is their OR. The pad input value is synchronized into the clock domain and can always be read back, whatever the pin's direction.

Register offsets from the port's configuration base are: 0 data out, 1 direction, 2 mode (0 = I/O, 1 = address out), and 3 pin input (read-only). Offsets 4 to 7 are unused.

Top module: `gpio_addrout_port`

## Requirements
- R1: While the synchronous active-high reset is asserted, data-out, direction and mode registers and the address latch clear to 00h. Pad enables are 00h after reset.
- R2: A write strobe with offset 0, 1 or 2 loads the write data into data-out, direction or mode on the next rising clock edge. A read at that offset returns the stored value.
- R3: A read at offset 3 returns the pad input after it has passed two clock flops, for every pin, regardless of direction.
- R4: Reads at offsets 4 to 7 return 00h. Writes at offsets 3 to 7 leave all three writable registers unchanged.
- R5: For each pin i, pad_oe[i] equals direction bit i ORed with pld_oe[i]. When pld_oe[i] is 0, the direction bit alone sets the enable.
- R6: When mode bit i is 0, pad_out[i] equals data-out bit i.
- R7: When mode bit i is 1, pad_out[i] equals latched address bit i: pins 3..0 carry a3..a0 and pins 7..4 carry a7..a4. Each pin selects independently of its neighbours.
- R8: The address latch loads addr_lo on the clock edge where ale is first seen high after being low. It holds while ale stays high, while ale stays low, and across changes of addr_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset from configuration base |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from offset) |
| ale | input | 1 | Address latch enable strobe |
| addr_lo | input | 8 | Low address byte from the bus |
| pld_oe | input | 8 | Per-pin output enable from programmable logic |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad tri-state enables, 1 = drive |

## Verification
The assertions take for granted that the write strobe and offset are settled before each rising edge. They also assume that addr_lo is held stable during the edge where an ale rise is detected, since the latch check compares against the previous cycle's address. The bench drives every input on the falling clock edge and holds addr_lo across each ale pulse. It changes addr_lo only while ale is steady, so the hold check on the latch is exercised without breaking these assumptions.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PIN_N  = 8;
    localparam int OFS_W  = 3;

    typedef enum logic [1:0] {
        OFS_DOUT = 2'd0,
        OFS_DIR  = 2'd1,
        OFS_MODE = 2'd2,
        OFS_PIN  = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [PIN_N-1:0] dout;
        logic [PIN_N-1:0] dir;
        logic [PIN_N-1:0] mode;
    } port_cfg_t;

    function automatic logic pin_drive(input logic mode_bit,
                                       input logic dout_bit,
                                       input logic addr_bit);
        return mode_bit ? addr_bit : dout_bit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = gpio_pkg::PIN_N,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_latch.sv
module gpio_addr_latch #(
    parameter int WIDTH = gpio_pkg::PIN_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ale,
    input  logic [WIDTH-1:0] addr_in,
    output logic [WIDTH-1:0] addr_q
);
    logic ale_d;
    logic ale_rise;

    assign ale_rise = ale & ~ale_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_d <= ale;
            if (ale_rise) addr_q <= addr_in;
        end
    end

    // R8
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ale && !ale_d) |=> (addr_q == $past(addr_in)));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ale && !ale_d) |=> $stable(addr_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = PIN_N,
    parameter int AW    = OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata,
    output port_cfg_t        cfg
);
    localparam int MAPPED = 4;

    logic     in_map;
    reg_ofs_e ofs;

    assign in_map = (int'(addr) < MAPPED);
    assign ofs    = reg_ofs_e'(addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr && in_map) begin
            unique case (ofs)
                OFS_DOUT: cfg.dout <= wdata;
                OFS_DIR:  cfg.dir  <= wdata;
                OFS_MODE: cfg.mode <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (in_map) begin
            unique case (ofs)
                OFS_DOUT: rdata = cfg.dout;
                OFS_DIR:  rdata = cfg.dir;
                OFS_MODE: rdata = cfg.mode;
                OFS_PIN:  rdata = pin_sync;
            endcase
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg == '0));

    // R2
    wr_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && int'(addr) == 1) |=> (cfg.dir == $past(wdata)));

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && int'(addr) >= 3) |=> $stable(cfg));

    // R4
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        !in_map |-> (rdata == '0));
endmodule

// File: rtl/gpio_addrout_port.sv
module gpio_addrout_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = PIN_N,
    parameter int AW    = OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WIDTH-1:0] cfg_wdata,
    output logic [WIDTH-1:0] cfg_rdata,
    input  logic             ale,
    input  logic [WIDTH-1:0] addr_lo,
    input  logic [WIDTH-1:0] pld_oe,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    port_cfg_t        cfg;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] addr_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_addr_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ale     (ale),
        .addr_in (addr_lo),
        .addr_q  (addr_q)
    );

    gpio_regs #(.WIDTH(WIDTH), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .pin_sync (pin_sync),
        .rdata    (cfg_rdata),
        .cfg      (cfg)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            assign pad_out[i] = pin_drive(cfg.mode[i], cfg.dout[i], addr_q[i]);
            assign pad_oe[i]  = cfg.dir[i] | pld_oe[i];
        end
    endgenerate

    // R5
    oe_follow_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && int'(cfg_addr) == 1) |=> ((pad_oe & ~pld_oe) == ($past(cfg_wdata) & ~pld_oe)));

    // R6
    io_mode_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && int'(cfg_addr) == 2 && cfg_wdata == '0) |=> (pad_out == cfg_rdata_dout_shadow));

    logic [WIDTH-1:0] cfg_rdata_dout_shadow;
    assign cfg_rdata_dout_shadow = cfg.dout;
endmodule

// File: tb/gpio_addrout_port_tb.sv
module gpio_addrout_port_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       ale;
    logic [7:0] addr_lo;
    logic [7:0] pld_oe;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    gpio_addrout_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ale       (ale),
        .addr_lo   (addr_lo),
        .pld_oe    (pld_oe),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // {dout, dir, mode, pld_oe, addr, expected pad_out, expected pad_oe}
    localparam logic [55:0] VEC [6] = '{
        {8'hA5, 8'h0F, 8'h00, 8'h00, 8'h3C, 8'hA5, 8'h0F},
        {8'hA5, 8'hFF, 8'hFF, 8'h00, 8'h3C, 8'h3C, 8'hFF},
        {8'h00, 8'h00, 8'h0F, 8'hF0, 8'hC3, 8'h03, 8'hF0},
        {8'hFF, 8'h81, 8'hF0, 8'h18, 8'h5A, 8'h5F, 8'h99},
        {8'h0F, 8'h07, 8'h55, 8'h00, 8'h96, 8'h1E, 8'h07},
        {8'h3C, 8'h00, 8'hAA, 8'h42, 8'h69, 8'h3C, 8'h42}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse_ale(input logic [7:0] a);
        @(negedge clk);
        addr_lo = a; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        ale = 1'b0; addr_lo = 8'hEE; pld_oe = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd0, r); chk("R1 dout", r, 8'h00);
        rd(3'd1, r); chk("R1 dir", r, 8'h00);
        rd(3'd2, r); chk("R1 mode", r, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // Vector table: R2 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            wr(3'd0, VEC[v][55:48]);
            wr(3'd1, VEC[v][47:40]);
            wr(3'd2, VEC[v][39:32]);
            pld_oe = VEC[v][31:24];
            pulse_ale(VEC[v][23:16]);
            #1;
            chk("R6 R7 pad_out", pad_out, VEC[v][15:8]);
            chk("R5 pad_oe", pad_oe, VEC[v][7:0]);
            rd(3'd0, r); chk("R2 dout readback", r, VEC[v][55:48]);
            rd(3'd1, r); chk("R2 dir readback", r, VEC[v][47:40]);
            rd(3'd2, r); chk("R2 mode readback", r, VEC[v][39:32]);
        end

        // R3 pin read regardless of direction, two-edge latency
        wr(3'd1, 8'h0F);
        @(negedge clk);
        pad_in = 8'h96;
        @(negedge clk);
        rd(3'd3, r); chk("R3 one edge old", r, 8'h00);
        @(negedge clk);
        rd(3'd3, r); chk("R3 pin read", r, 8'h96);

        // R4 unmapped read, writes to read-only and unmapped offsets
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33);
        rd(3'd5, r); chk("R4 unmapped read", r, 8'h00);
        rd(3'd7, r); chk("R4 unmapped read 7", r, 8'h00);
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
        rd(3'd0, r); chk("R4 dout kept", r, 8'h11);
        rd(3'd1, r); chk("R4 dir kept", r, 8'h22);
        rd(3'd2, r); chk("R4 mode kept", r, 8'h33);
        rd(3'd3, r); chk("R4 pin unaffected", r, 8'h96);

        // R8 latch edge behaviour, all pins in address mode
        pld_oe = '0;
        wr(3'd2, 8'hFF);
        pulse_ale(8'hA1);
        chk("R8 capture", pad_out, 8'hA1);
        addr_lo = 8'h5E;
        @(negedge clk); @(negedge clk);
        chk("R8 hold ale low", pad_out, 8'hA1);
        ale = 1'b1; addr_lo = 8'h77;
        @(negedge clk);
        addr_lo = 8'h12;
        @(negedge clk); @(negedge clk);
        chk("R8 hold ale high", pad_out, 8'h77);
        ale = 1'b0;
        pulse_ale(8'hC4);
        chk("R8 recapture", pad_out, 8'hC4);

        // R5 direction only when external enable inactive
        wr(3'd1, 8'h3C);
        pld_oe = 8'h00; #1;
        chk("R5 dir alone", pad_oe, 8'h3C);
        pld_oe = 8'h81; #1;
        chk("R5 or term", pad_oe, 8'hBD);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule